// File: doc/BRIEF.md
# Parallel Port Mode and Status Register Block

This block is the host-facing register set of a PC-style parallel port. Software reaches four byte-wide registers over a simple read/write bus: a data latch, a status register, a control latch and an extended-control register. The top three bits of the extended-control register choose the port's operating mode. The block decodes that field into a two-bit mode code that drives the rest of the port. Bit 0 of the same register shows whether the FIFO is empty. The FIFO itself is not built here: an occupancy input stands in for it.

Bit 0 of the status register is a sticky EPP timeout flag. It sets when a modelled EPP cycle stays active longer than a programmable number of clocks. Software clears it with a two-step write sequence. A sync engine answers a drain request. In EPP mode it polls the FIFO-empty condition up to a fixed number of times and reports success or failure. In any other mode it answers at once. The data and control latches read back what was written, so software can test for the port's presence, for example by writing 0x0C to control and 0xAA to data.

Top module: `pport_mode_ctrl`

## Requirements
- R1: After reset the data, control and extended-control fields read 0, the mode output is standard (0), the timeout flag is clear and no sync completion is signalled. With the FIFO empty, the extended-control register then reads 0x01.
- R2: Register offsets are 0 data, 1 status, 2 control and 3 extended control. Reads are registered: `bus_rdata` is valid in the cycle after `bus_rd`. The data and control registers read back the last value written.
- R3: On a write to extended control, bits [7:5] set `port_mode_o` from the next cycle. The codes are: 000 gives standard (0), 001 gives PS/2 bidirectional (1), 011 gives ECP (2) and 100 gives EPP (3).
- R4: The reserved codes 010, 101, 110 and 111 read back in bits [7:5] exactly as written, and they put `port_mode_o` in standard (0).
- R5: Extended-control bits [7:1] read back as written. Bit 0 reads 1 when `fifo_level_i` is zero and 0 otherwise. Writes to bit 0 have no effect.
- R6: When the mode field is not 100, a sync request produces `sync_done_o` = 1 with `sync_fail_o` = 0 in the cycle after the request.
- R7: When the mode field is 100, a sync request starts polling once per clock, beginning on the clock after the request. The first poll that sees the FIFO empty ends the sync with `sync_done_o` = 1 and `sync_fail_o` = 0. If POLL_LIMIT polls all see data, the sync ends with `sync_done_o` = 1 and `sync_fail_o` = 1. Both outputs are single-cycle pulses.
- R8: In EPP mode, if `epp_cycle_i` is held high over TIMEOUT_CYCLES+1 consecutive clock edges, status bit 0 sets. Holding it for TIMEOUT_CYCLES edges does not set the bit. Outside EPP mode the bit never sets.
- R9: Once set, status bit 0 stays set. A status write with bit 0 = 0 clears it only if the previous status write had bit 0 = 1; writes to other registers in between do not matter. No status write ever sets the bit.
- R10: Status bits [7:1] read the live `pin_status_i` inputs, and status writes have no effect on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_status_i | input | 7 | Live status lines shown in status bits [7:1] |
| fifo_level_i | input | FIFO_LW | Modelled FIFO occupancy |
| epp_cycle_i | input | 1 | High while a modelled EPP cycle is in progress |
| sync_req_i | input | 1 | Single-cycle request to wait for the FIFO to drain |
| sync_done_o | output | 1 | Pulse: sync finished |
| sync_fail_o | output | 1 | With done: data still present |
| port_mode_o | output | 2 | Decoded mode: 0 std, 1 PS/2, 2 ECP, 3 EPP |

## Verification
The bench builds the block with POLL_LIMIT = 6, TIMEOUT_CYCLES = 4 and FIFO_LW = 4. With these values the exact poll that fails a sync can be counted in a few clocks, and the timeout threshold can be probed on both sides, at four and at five active edges. The small limits also let the bench check every mode code, reserved ones included, and the armed/unarmed clear sequence within a short run.

// File: rtl/pport_pkg.sv
package pport_pkg;

  typedef enum logic [1:0] {
    PM_STD = 2'd0,
    PM_PS2 = 2'd1,
    PM_ECP = 2'd2,
    PM_EPP = 2'd3
  } pmode_e;

  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;
  localparam logic [1:0] A_XCTL = 2'd3;

  localparam logic [2:0] F_PS2 = 3'b001;
  localparam logic [2:0] F_ECP = 3'b011;
  localparam logic [2:0] F_EPP = 3'b100;

  function automatic pmode_e decode_mode(input logic [2:0] f);
    case (f)
      F_PS2:   return PM_PS2;
      F_ECP:   return PM_ECP;
      F_EPP:   return PM_EPP;
      default: return PM_STD;
    endcase
  endfunction

endpackage

// File: rtl/pport_regs.sv
module pport_regs
  import pport_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] addr,
  input  logic       wr,
  input  logic       rd,
  input  logic [7:0] wdata,
  input  logic [6:0] pins,
  input  logic       fifo_empty,
  input  logic       tmo_flag,
  output logic [7:0] rdata,
  output pmode_e     mode
);

  logic [7:0] data_q;
  logic [7:0] ctrl_q;
  logic [7:1] xctl_q;
  logic [7:0] rd_mux;

  always_comb begin
    case (addr)
      A_DATA:  rd_mux = data_q;
      A_STAT:  rd_mux = {pins, tmo_flag};
      A_CTRL:  rd_mux = ctrl_q;
      default: rd_mux = {xctl_q, fifo_empty};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      ctrl_q <= '0;
      xctl_q <= '0;
      mode   <= PM_STD;
      rdata  <= '0;
    end else begin
      if (wr) begin
        case (addr)
          A_DATA: data_q <= wdata;
          A_CTRL: ctrl_q <= wdata;
          A_XCTL: begin
            xctl_q <= wdata[7:1];
            mode   <= decode_mode(wdata[7:5]);
          end
          default: ;
        endcase
      end
      if (rd) rdata <= rd_mux;
    end
  end

  // R2: a data read returns the latch value held at the time of the read
  a_r2_data_read: assert property (@(posedge clk) disable iff (rst)
    (rd && addr == A_DATA) |=> (rdata == $past(data_q)));

  // R4: reserved codes leave the port in standard mode
  a_r4_reserved_std: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == A_XCTL && wdata[7:5] != F_PS2 && wdata[7:5] != F_ECP
     && wdata[7:5] != F_EPP) |=> (mode == PM_STD));

  // R5: extended-control bit 0 follows the FIFO-empty input
  a_r5_empty_bit: assert property (@(posedge clk) disable iff (rst)
    (rd && addr == A_XCTL) |=> (rdata[0] == $past(fifo_empty)));

endmodule

// File: rtl/pport_tmo.sv
module pport_tmo #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic epp_mode,
  input  logic epp_cycle,
  input  logic sts_wr,
  input  logic sts_bit0,
  output logic flag
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;
  logic          armed;
  logic          fire;
  logic          clr;

  assign fire = epp_mode && epp_cycle && (cnt == LIM);
  assign clr  = sts_wr && !sts_bit0 && armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      flag  <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (epp_mode && epp_cycle) begin
        if (cnt != LIM) cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
      end
      if (fire)     flag <= 1'b1;
      else if (clr) flag <= 1'b0;
      if (sts_wr)   armed <= sts_bit0;
    end
  end

  // R9: the flag holds unless a status write with bit 0 clear arrives
  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag && !(sts_wr && !sts_bit0)) |=> flag);

  // R9: an unarmed clear write leaves the flag set
  a_r9_unarmed: assert property (@(posedge clk) disable iff (rst)
    (flag && sts_wr && !sts_bit0 && !armed) |=> flag);

  // R8: outside EPP mode a clear flag never sets
  a_r8_no_set: assert property (@(posedge clk) disable iff (rst)
    (!flag && !epp_mode) |=> !flag);

endmodule

// File: rtl/pport_sync.sv
module pport_sync #(
  parameter int POLL_LIMIT = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic epp_mode,
  input  logic fifo_empty,
  output logic done,
  output logic fail
);

  localparam int PW = $clog2(POLL_LIMIT + 1);
  localparam logic [PW-1:0] LAST = PW'(POLL_LIMIT - 1);

  logic          busy;
  logic [PW-1:0] polls;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      polls <= '0;
      done  <= 1'b0;
      fail  <= 1'b0;
    end else begin
      done <= 1'b0;
      fail <= 1'b0;
      if (!busy) begin
        if (req) begin
          if (epp_mode) begin
            busy  <= 1'b1;
            polls <= '0;
          end else begin
            done <= 1'b1;
          end
        end
      end else if (fifo_empty) begin
        done <= 1'b1;
        busy <= 1'b0;
      end else if (polls == LAST) begin
        done <= 1'b1;
        fail <= 1'b1;
        busy <= 1'b0;
      end else begin
        polls <= polls + 1'b1;
      end
    end
  end

  // R6: outside EPP mode a request completes at once without failure
  a_r6_immediate: assert property (@(posedge clk) disable iff (rst)
    (req && !busy && !epp_mode) |=> (done && !fail));

  // R7: failure is only reported together with completion
  a_r7_fail_done: assert property (@(posedge clk) disable iff (rst)
    fail |-> done);

  // R7: a poll that sees an empty FIFO ends the sync successfully
  a_r7_empty_ok: assert property (@(posedge clk) disable iff (rst)
    (busy && fifo_empty) |=> (done && !fail));

endmodule

// File: rtl/pport_mode_ctrl.sv
module pport_mode_ctrl
  import pport_pkg::*;
#(
  parameter int FIFO_LW        = 5,
  parameter int POLL_LIMIT     = 100,
  parameter int TIMEOUT_CYCLES = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [7:0]         bus_wdata,
  output logic [7:0]         bus_rdata,
  input  logic [6:0]         pin_status_i,
  input  logic [FIFO_LW-1:0] fifo_level_i,
  input  logic               epp_cycle_i,
  input  logic               sync_req_i,
  output logic               sync_done_o,
  output logic               sync_fail_o,
  output logic [1:0]         port_mode_o
);

  pmode_e mode;
  logic   fifo_empty;
  logic   epp_mode;
  logic   tmo_flag;
  logic   sts_wr;

  assign fifo_empty  = (fifo_level_i == '0);
  assign epp_mode    = (mode == PM_EPP);
  assign sts_wr      = bus_wr && (bus_addr == A_STAT);
  assign port_mode_o = mode;

  pport_regs u_regs (
    .clk        (clk),
    .rst        (rst),
    .addr       (bus_addr),
    .wr         (bus_wr),
    .rd         (bus_rd),
    .wdata      (bus_wdata),
    .pins       (pin_status_i),
    .fifo_empty (fifo_empty),
    .tmo_flag   (tmo_flag),
    .rdata      (bus_rdata),
    .mode       (mode)
  );

  pport_tmo #(.LIMIT(TIMEOUT_CYCLES)) u_tmo (
    .clk       (clk),
    .rst       (rst),
    .epp_mode  (epp_mode),
    .epp_cycle (epp_cycle_i),
    .sts_wr    (sts_wr),
    .sts_bit0  (bus_wdata[0]),
    .flag      (tmo_flag)
  );

  pport_sync #(.POLL_LIMIT(POLL_LIMIT)) u_sync (
    .clk        (clk),
    .rst        (rst),
    .req        (sync_req_i),
    .epp_mode   (epp_mode),
    .fifo_empty (fifo_empty),
    .done       (sync_done_o),
    .fail       (sync_fail_o)
  );

  // R3: an EPP code written to extended control selects EPP mode next cycle
  a_r3_epp_select: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_XCTL && bus_wdata[7:5] == F_EPP) |=> (port_mode_o == 2'd3));

endmodule

// File: tb/pport_mode_ctrl_bench.sv
module pport_mode_ctrl_bench;

  localparam int FLW = 4;
  localparam int PL  = 6;
  localparam int TC  = 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [1:0]     bus_addr = '0;
  logic           bus_wr = 1'b0;
  logic           bus_rd = 1'b0;
  logic [7:0]     bus_wdata = '0;
  logic [7:0]     bus_rdata;
  logic [6:0]     pin_status_i = 7'h5A;
  logic [FLW-1:0] fifo_level_i = '0;
  logic           epp_cycle_i = 1'b0;
  logic           sync_req_i = 1'b0;
  logic           sync_done_o;
  logic           sync_fail_o;
  logic [1:0]     port_mode_o;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  pport_mode_ctrl #(.FIFO_LW(FLW), .POLL_LIMIT(PL), .TIMEOUT_CYCLES(TC)) u_pport_mode_ctrl (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_status_i(pin_status_i),
    .fifo_level_i(fifo_level_i), .epp_cycle_i(epp_cycle_i), .sync_req_i(sync_req_i),
    .sync_done_o(sync_done_o), .sync_fail_o(sync_fail_o), .port_mode_o(port_mode_o)
  );

  // {write value, expected read with FIFO empty, expected mode}
  localparam logic [17:0] VEC [8] = '{
    {8'h00, 8'h01, 2'd0}, {8'h20, 8'h21, 2'd1}, {8'h40, 8'h41, 2'd0},
    {8'h7E, 8'h7F, 2'd2}, {8'h80, 8'h81, 2'd3}, {8'hA0, 8'hA1, 2'd0},
    {8'hD4, 8'hD5, 2'd0}, {8'hFF, 8'hFF, 2'd0}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] r;
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 mode", port_mode_o, 0);
    check("R1 done", sync_done_o, 0);
    rd_reg(2'd0, r); check("R1 data", r, 8'h00);
    rd_reg(2'd2, r); check("R1 ctrl", r, 8'h00);
    rd_reg(2'd3, r); check("R1 xctl", r, 8'h01);
    rd_reg(2'd1, r); check("R1 status", r, 8'hB4);

    // R2 presence test and read-back
    wr_reg(2'd2, 8'h0C);
    wr_reg(2'd0, 8'hAA);
    rd_reg(2'd0, r); check("R2 data 0xAA", r, 8'hAA);
    rd_reg(2'd2, r); check("R2 ctrl 0x0C", r, 8'h0C);
    wr_reg(2'd0, 8'h55);
    rd_reg(2'd0, r); check("R2 data 0x55", r, 8'h55);

    // R3 R4 R5 mode table walk
    for (int i = 0; i < 8; i++) begin
      wr_reg(2'd3, VEC[i][17:10]);
      check("R3 R4 mode", port_mode_o, int'(VEC[i][1:0]));
      rd_reg(2'd3, r);
      check("R4 R5 xctl read", r, int'(VEC[i][9:2]));
    end

    // R5 bit 0 tracks non-empty FIFO, write to bit 0 ignored
    fifo_level_i = 4'd3;
    rd_reg(2'd3, r); check("R5 nonempty", r, 8'hFE);
    fifo_level_i = 4'd0;

    // R10 status pins live, writes do not alter them
    wr_reg(2'd1, 8'hFE);
    rd_reg(2'd1, r); check("R10 status after write", r, 8'hB4);
    pin_status_i = 7'h21;
    rd_reg(2'd1, r); check("R10 status pins", r, 8'h42);

    // R6 immediate sync in standard and ECP mode
    fifo_level_i = 4'd5;
    wr_reg(2'd3, 8'h00);
    @(negedge clk); sync_req_i = 1'b1;
    @(negedge clk); sync_req_i = 1'b0;
    check("R6 std done", sync_done_o, 1);
    check("R6 std fail", sync_fail_o, 0);
    wr_reg(2'd3, 8'h60);
    @(negedge clk); sync_req_i = 1'b1;
    @(negedge clk); sync_req_i = 1'b0;
    check("R6 ecp done", sync_done_o, 1);
    check("R6 ecp fail", sync_fail_o, 0);

    // R7 EPP sync failing after POLL_LIMIT polls
    wr_reg(2'd3, 8'h80);
    @(negedge clk); sync_req_i = 1'b1;
    @(negedge clk); sync_req_i = 1'b0;
    n = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk); n++;
      if (sync_done_o) break;
    end
    check("R7 fail latency", n, PL);
    check("R7 fail flag", sync_fail_o, 1);
    @(negedge clk);
    check("R7 done pulse", sync_done_o, 0);

    // R7 EPP sync succeeding once FIFO drains
    @(negedge clk); sync_req_i = 1'b1;
    @(negedge clk); sync_req_i = 1'b0;
    n = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk); n++;
      if (sync_done_o) break;
      if (n == 3) fifo_level_i = 4'd0;
    end
    check("R7 ok latency", n, 4);
    check("R7 ok flag", sync_fail_o, 0);

    // R8 threshold in EPP mode (mode already EPP)
    pin_status_i = 7'h00;
    @(negedge clk); epp_cycle_i = 1'b1;
    repeat (TC) @(negedge clk);
    epp_cycle_i = 1'b0;
    rd_reg(2'd1, r); check("R8 below threshold", r, 8'h00);
    @(negedge clk); epp_cycle_i = 1'b1;
    repeat (TC + 1) @(negedge clk);
    epp_cycle_i = 1'b0;
    rd_reg(2'd1, r); check("R8 at threshold", r, 8'h01);

    // R9 clear sequence
    wr_reg(2'd1, 8'h00);
    rd_reg(2'd1, r); check("R9 unarmed clear", r, 8'h01);
    wr_reg(2'd1, 8'h01);
    rd_reg(2'd1, r); check("R9 arm keeps flag", r, 8'h01);
    wr_reg(2'd2, 8'h33);
    wr_reg(2'd1, 8'h00);
    rd_reg(2'd1, r); check("R9 armed clear", r, 8'h00);
    wr_reg(2'd1, 8'h01);
    rd_reg(2'd1, r); check("R9 write never sets", r, 8'h00);

    // R8 no set outside EPP mode
    wr_reg(2'd3, 8'h20);
    @(negedge clk); epp_cycle_i = 1'b1;
    repeat (3 * TC) @(negedge clk);
    epp_cycle_i = 1'b0;
    rd_reg(2'd1, r); check("R8 not in EPP", r, 8'h00);

    // R1 reset again clears everything
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 mode after reset", port_mode_o, 0);
    rd_reg(2'd2, r); check("R1 ctrl after reset", r, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule